// File: doc/BRIEF.md
# Shared-ALU Multi-Cycle Processor Datapath

This block is the 32-bit datapath of a load/store processor that spends several clock cycles on each instruction. One arithmetic unit serves operand arithmetic, address generation, PC increment and branch-target arithmetic. One memory port serves both instruction fetch and data access. Values passed from one cycle to the next are held in internal registers: the program counter, the instruction register, the memory data register, two operand registers and an ALU result register. A 32-entry register file stores the architectural state.

The block has no sequencer. Every mux select and write enable is a separate input, and an external controller, or a testbench, drives them cycle by cycle. The block returns the instruction's opcode field and the ALU zero flag to that controller. The memory sits outside the block. It sees a single address bus, a write-data bus and read/write strobes, and it returns read data combinationally.

Top module: `mcd_datapath`

## Requirements
- R1: A synchronous active-high reset sets the PC and the instruction register to zero. After reset, with the address select at 0, `mem_addr` is 0 and `opcode` is 0.
- R2: Fetch step. With `ctl_ir_wr`=1, the instruction register captures `mem_rdata` at the clock edge. The next fetch address is PC+4. This uses `ctl_srca`=0, `ctl_srcb`=01 (constant 4), `ctl_alu_mode`=00 and `ctl_pc_src`=00 (live ALU result) with `ctl_pc_wr`=1. `opcode` carries instruction bits [31:26].
- R3: While `ctl_ir_wr` is 0, the instruction register keeps its value whatever `mem_rdata` carries.
- R4: Load. With `ctl_srca`=1 and `ctl_srcb`=10, the ALU adds register A (read through bits [25:21]) to the sign-extended bits [15:0]. `ctl_addr_sel`=1 puts the registered ALU result on `mem_addr`. The memory data register captures `mem_rdata` on every edge. With `ctl_wb_sel`=1, `ctl_dst_sel`=0 and `ctl_rf_wr`=1, that value is written to the register named by bits [20:16].
- R5: Store. `mem_wdata` carries operand register B, read through bits [20:16]. `mem_wr` and `mem_rd` follow `ctl_mem_wr` and `ctl_mem_rd`.
- R6: With `ctl_alu_mode`=10, the operation comes from bits [5:0]: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-less-than. Add and subtract wrap modulo 2^32. With `ctl_dst_sel`=1 and `ctl_wb_sel`=0, the result is written to the register named by bits [15:11].
- R7: Register 0 always reads as zero, even after a write to it.
- R8: The PC loads when `ctl_pc_wr`=1, or when `ctl_pc_wr_cond`=1 and the ALU zero flag is set. With `ctl_srcb`=11 the ALU forms PC + (sign-extended bits [15:0] << 2). `ctl_pc_src`=01 then loads that registered result.
- R9: With `ctl_pc_src`=10 and `ctl_pc_wr`=1, the PC loads {PC[31:28], IR[25:0], 00}.
- R10: `alu_zero` is 1 exactly when the live ALU result is zero.
- R11: `ctl_alu_mode`=00 forces add and 01 forces subtract, whatever the bits [5:0] hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pc_wr | input | 1 | Unconditional PC load |
| ctl_pc_wr_cond | input | 1 | PC load when ALU result is zero |
| ctl_addr_sel | input | 1 | Memory address: 0 PC, 1 registered ALU result |
| ctl_mem_rd | input | 1 | Memory read request |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_ir_wr | input | 1 | Instruction register load |
| ctl_wb_sel | input | 1 | Write-back data: 0 ALU result register, 1 memory data register |
| ctl_dst_sel | input | 1 | Write-back index: 0 bits [20:16], 1 bits [15:11] |
| ctl_rf_wr | input | 1 | Register file write enable |
| ctl_srca | input | 1 | ALU first operand: 0 PC, 1 register A |
| ctl_srcb | input | 2 | ALU second operand: 00 B, 01 four, 10 imm, 11 imm<<2 |
| ctl_alu_mode | input | 2 | 00 add, 01 subtract, 10 function field |
| ctl_pc_src | input | 2 | 00 live ALU, 01 registered ALU, 10 jump target |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction bits [31:26] |
| alu_zero | output | 1 | ALU result equals zero |

## Verification
Each function code is applied to operands loaded from memory. The operands are chosen to separate the codes: AND and OR produce different bit patterns, add and subtract both wrap, and a negative-versus-positive pair gives opposite signed and unsigned set-less-than results. The results come out through store cycles on `mem_wdata`. Immediates whose low bits look like function codes show whether fixed add and fixed subtract ignore the function field. Equal and unequal branch operands check the zero flag and the conditional PC load. A jump and the next fetch address check the jump target composition.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  typedef enum logic [1:0] {
    SRCB_REG    = 2'b00,
    SRCB_FOUR   = 2'b01,
    SRCB_IMM    = 2'b10,
    SRCB_IMM_SH = 2'b11
  } srcb_e;

  typedef enum logic [1:0] {
    PCS_LIVE = 2'b00,
    PCS_HELD = 2'b01,
    PCS_JUMP = 2'b10,
    PCS_RSV  = 2'b11
  } pcsrc_e;

  typedef enum logic [1:0] {
    MODE_ADD   = 2'b00,
    MODE_SUB   = 2'b01,
    MODE_FUNCT = 2'b10,
    MODE_RSV   = 2'b11
  } amode_e;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_SUB,
    OP_AND,
    OP_OR,
    OP_SLT
  } aluop_e;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];
  logic [W-1:0] q0, q1;
  logic         z0, z1;

  // Synchronous read with old-data semantics; the read registers act as
  // the A and B operand registers of the datapath.
  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
    q0 <= store[ra0];
    q1 <= store[ra1];
    z0 <= (ra0 == '0);
    z1 <= (ra1 == '0);
  end

  assign rd0 = z0 ? '0 : q0;
  assign rd1 = z1 ? '0 : q1;
endmodule

// File: rtl/mcd_alu_ctl.sv
module mcd_alu_ctl
  import mcd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [5:0] funct,
  output aluop_e     op
);
  always_comb begin
    unique case (amode_e'(mode))
      MODE_SUB:   op = OP_SUB;
      MODE_FUNCT: begin
        unique case (funct)
          FN_SUB:  op = OP_SUB;
          FN_AND:  op = OP_AND;
          FN_OR:   op = OP_OR;
          FN_SLT:  op = OP_SLT;
          default: op = OP_ADD;
        endcase
      end
      default:    op = OP_ADD;
    endcase
  end
endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int W = 32
) (
  input  aluop_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath
  import mcd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_pc_wr,
  input  logic            ctl_pc_wr_cond,
  input  logic            ctl_addr_sel,
  input  logic            ctl_mem_rd,
  input  logic            ctl_mem_wr,
  input  logic            ctl_ir_wr,
  input  logic            ctl_wb_sel,
  input  logic            ctl_dst_sel,
  input  logic            ctl_rf_wr,
  input  logic            ctl_srca,
  input  logic [1:0]      ctl_srcb,
  input  logic [1:0]      ctl_alu_mode,
  input  logic [1:0]      ctl_pc_src,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [5:0]      opcode,
  output logic            alu_zero
);
  localparam int REG_AW  = 5;
  localparam int IMM_W   = 16;
  localparam int JIDX_W  = 26;
  localparam int PCHI_W  = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, aluout_q;
  logic [XLEN-1:0] a_q, b_q;
  logic [XLEN-1:0] opnd_a, opnd_b, alu_y, pc_next, imm_sx, wb_data;
  logic [REG_AW-1:0] rs_f, rt_f, rd_f, wr_idx;
  aluop_e alu_op;

  assign rs_f   = ir_q[25:21];
  assign rt_f   = ir_q[20:16];
  assign rd_f   = ir_q[15:11];
  assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

  assign wr_idx  = ctl_dst_sel ? rd_f : rt_f;
  assign wb_data = ctl_wb_sel ? mdr_q : aluout_q;

  mcd_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk (clk),
    .we  (ctl_rf_wr),
    .wa  (wr_idx),
    .wd  (wb_data),
    .ra0 (rs_f),
    .ra1 (rt_f),
    .rd0 (a_q),
    .rd1 (b_q)
  );

  assign opnd_a = ctl_srca ? a_q : pc_q;

  always_comb begin
    unique case (srcb_e'(ctl_srcb))
      SRCB_FOUR:   opnd_b = XLEN'(4);
      SRCB_IMM:    opnd_b = imm_sx;
      SRCB_IMM_SH: opnd_b = {imm_sx[XLEN-3:0], 2'b00};
      default:     opnd_b = b_q;
    endcase
  end

  mcd_alu_ctl u_actl (
    .mode  (ctl_alu_mode),
    .funct (ir_q[5:0]),
    .op    (alu_op)
  );

  mcd_alu #(.W(XLEN)) u_alu (
    .op   (alu_op),
    .a    (opnd_a),
    .b    (opnd_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  always_comb begin
    unique case (pcsrc_e'(ctl_pc_src))
      PCS_HELD: pc_next = aluout_q;
      PCS_JUMP: pc_next = {pc_q[XLEN-1 -: PCHI_W], ir_q[JIDX_W-1:0], 2'b00};
      default:  pc_next = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      aluout_q <= '0;
    end else begin
      if (ctl_pc_wr || (ctl_pc_wr_cond && alu_zero)) pc_q <= pc_next;
      if (ctl_ir_wr) ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      aluout_q <= alu_y;
    end
  end

  assign mem_addr  = ctl_addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd    = ctl_mem_rd;
  assign mem_wr    = ctl_mem_wr;
  assign opcode    = ir_q[31:26];
endmodule

// File: rtl/mcd_datapath_chk.sv
module mcd_datapath_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            ctl_pc_wr,
  input logic            ctl_pc_wr_cond,
  input logic            ctl_ir_wr,
  input logic            alu_zero,
  input logic [XLEN-1:0] mem_rdata,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] ir_q,
  input logic [XLEN-1:0] mdr_q
);
  // R1: a reset cycle leaves the PC at zero
  a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc_q == '0));

  // R2: instruction register captures memory data when enabled
  a_r2_ir_load: assert property (@(posedge clk) disable iff (rst)
    ctl_ir_wr |=> (ir_q == $past(mem_rdata)));

  // R3: instruction register holds when not enabled
  a_r3_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl_ir_wr |=> $stable(ir_q));

  // R4: memory data register samples read data each cycle
  a_r4_mdr_capture: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mdr_q == $past(mem_rdata)));

  // R8: no load condition means the PC keeps its value
  a_r8_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl_pc_wr && !(ctl_pc_wr_cond && alu_zero)) |=> $stable(pc_q));
endmodule

bind mcd_datapath mcd_datapath_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ctl_pc_wr      (ctl_pc_wr),
  .ctl_pc_wr_cond (ctl_pc_wr_cond),
  .ctl_ir_wr      (ctl_ir_wr),
  .alu_zero       (alu_zero),
  .mem_rdata      (mem_rdata),
  .pc_q           (pc_q),
  .ir_q           (ir_q),
  .mdr_q          (mdr_q)
);

// File: tb/tb_mcd_datapath.sv
`timescale 1ns/1ps
module tb_mcd_datapath;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        c_pc_wr, c_pc_wr_cond, c_addr_sel, c_mem_rd, c_mem_wr, c_ir_wr;
  logic        c_wb_sel, c_dst_sel, c_rf_wr, c_srca;
  logic [1:0]  c_srcb, c_mode, c_pc_src;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_rd, mem_wr, alu_zero;
  logic [5:0]  opcode;

  logic [31:0] mem [256];
  logic [31:0] pc_e;
  int          checks = 0;
  int          failures = 0;
  string       ftag = "R2";

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  mcd_datapath dut (
    .clk(clk), .rst(rst),
    .ctl_pc_wr(c_pc_wr), .ctl_pc_wr_cond(c_pc_wr_cond), .ctl_addr_sel(c_addr_sel),
    .ctl_mem_rd(c_mem_rd), .ctl_mem_wr(c_mem_wr), .ctl_ir_wr(c_ir_wr),
    .ctl_wb_sel(c_wb_sel), .ctl_dst_sel(c_dst_sel), .ctl_rf_wr(c_rf_wr),
    .ctl_srca(c_srca), .ctl_srcb(c_srcb), .ctl_alu_mode(c_mode), .ctl_pc_src(c_pc_src),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .opcode(opcode), .alu_zero(alu_zero)
  );

  typedef struct packed {
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] y;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{6'b100000, 32'd5,          32'd7,          32'd12},
    '{6'b100010, 32'd3,          32'd10,         32'hFFFF_FFF9},
    '{6'b100100, 32'hF0F0_1234,  32'h0FF0_FF00,  32'h00F0_1200},
    '{6'b100101, 32'hF000_0000,  32'h0000_000F,  32'hF000_000F},
    '{6'b101010, 32'hFFFF_FFFF,  32'd1,          32'd1},
    '{6'b101010, 32'd1,          32'hFFFF_FFFF,  32'd0},
    '{6'b100000, 32'hFFFF_FFFF,  32'd2,          32'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_ctl();
    {c_pc_wr, c_pc_wr_cond, c_addr_sel, c_mem_rd, c_mem_wr, c_ir_wr} = '0;
    {c_wb_sel, c_dst_sel, c_rf_wr, c_srca} = '0;
    c_srcb = 2'b00; c_mode = 2'b00; c_pc_src = 2'b00;
  endtask

  task automatic step();
    @(negedge clk);
    clear_ctl();
  endtask

  task automatic do_fetch(input logic [31:0] ins);
    mem[pc_e[9:2]] = ins;
    step(); c_ir_wr = 1; c_mem_rd = 1; c_srcb = 2'b01; c_pc_wr = 1; #1;
    chk(ftag, mem_addr, pc_e);
    ftag = "R2";
    pc_e = pc_e + 4;
  endtask

  task automatic do_decode(input logic [5:0] op_exp);
    step(); c_srcb = 2'b11; #1;
    chk("R2 opcode", {26'd0, opcode}, {26'd0, op_exp});
  endtask

  task automatic do_load(input logic [4:0] rt, input logic [15:0] imm, input string tag);
    do_fetch({6'h23, 5'd0, rt, imm});
    do_decode(6'h23);
    step(); c_srca = 1; c_srcb = 2'b10;
    step(); c_addr_sel = 1; c_mem_rd = 1; #1;
    chk(tag, mem_addr, {{16{imm[15]}}, imm});
    step(); c_wb_sel = 1; c_rf_wr = 1;
  endtask

  task automatic do_store(input logic [4:0] rt, input logic [15:0] imm,
                          input logic [31:0] val, input string tag);
    do_fetch({6'h2B, 5'd0, rt, imm});
    do_decode(6'h2B);
    step(); c_srca = 1; c_srcb = 2'b10;
    step(); c_addr_sel = 1; c_mem_wr = 1; #1;
    chk("R5 addr", mem_addr, {{16{imm[15]}}, imm});
    chk("R5 strobe", {30'd0, mem_wr, mem_rd}, 32'd2);
    chk(tag, mem_wdata, val);
  endtask

  task automatic do_rtype(input logic [4:0] rd, input logic [4:0] rs,
                          input logic [4:0] rt, input logic [5:0] fn);
    do_fetch({6'h00, rs, rt, rd, 5'd0, fn});
    do_decode(6'h00);
    step(); c_srca = 1; c_srcb = 2'b00; c_mode = 2'b10;
    step(); c_dst_sel = 1; c_rf_wr = 1;
  endtask

  task automatic do_branch(input logic [4:0] rs, input logic [4:0] rt,
                           input logic [15:0] off, input logic taken, input string tag);
    do_fetch({6'h04, rs, rt, off});
    do_decode(6'h04);
    step(); c_srca = 1; c_mode = 2'b01; c_pc_wr_cond = 1; c_pc_src = 2'b01; #1;
    chk(tag, {31'd0, alu_zero}, {31'd0, taken});
    if (taken) pc_e = pc_e + {{14{off[15]}}, off, 2'b00};
    ftag = "R8 next fetch";
  endtask

  task automatic do_jump(input logic [25:0] tgt);
    do_fetch({6'h02, tgt});
    do_decode(6'h02);
    step(); c_pc_src = 2'b10; c_pc_wr = 1;
    pc_e = {pc_e[31:28], tgt, 2'b00};
    ftag = "R9 jump target";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    clear_ctl();
    pc_e = 32'h0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    // R1: reset state visible at the ports
    chk("R1 pc", mem_addr, 32'h0);
    chk("R1 opcode", {26'd0, opcode}, 32'h0);

    // R6 (with R4, R5): function-code table
    for (int k = 0; k < 7; k++) begin
      mem[192] = VECS[k].a;
      mem[193] = VECS[k].b;
      do_load(5'd1, 16'h0300, "R4 addr");
      do_load(5'd2, 16'h0304, "R4 addr");
      do_rtype(5'd3, 5'd1, 5'd2, VECS[k].fn);
      do_store(5'd3, 16'h0308, VECS[k].y, "R6 result");
    end

    // R3: instruction register ignores new memory data while not enabled
    mem[pc_e[9:2]] = 32'hFC00_0000;
    step(); #1;
    step(); #1;
    chk("R3 hold", {26'd0, opcode}, 32'h0000_002B);

    // R7: write to register 0 is discarded
    do_rtype(5'd0, 5'd1, 5'd2, 6'b100000);
    do_store(5'd0, 16'h030C, 32'h0, "R7 zero reg");

    // R11: immediate low bits resemble a subtract code; fixed add still used
    mem[200] = 32'h0000_A5A5;
    mem[201] = 32'h0000_005A;
    do_load(5'd4, 16'h0322, "R11 add forced");
    do_load(5'd5, 16'h0324, "R4 addr");
    do_store(5'd4, 16'h0310, 32'h0000_A5A5, "R4 load data");

    // R10/R11: equal operands, offset low bits resemble an AND code
    do_branch(5'd4, 5'd4, 16'h0024, 1'b1, "R10 zero set, R11 sub forced");
    do_store(5'd5, 16'h0314, 32'h0000_005A, "R5 data");

    // R8: unequal operands, no branch
    do_branch(5'd4, 5'd5, 16'h0003, 1'b0, "R10 zero clear");
    do_store(5'd4, 16'h0318, 32'h0000_A5A5, "R5 data");

    // R9: jump
    do_jump(26'h0000010);
    do_store(5'd5, 16'h031C, 32'h0000_005A, "R5 data");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule